// File: doc/BRIEF.md
# Active Power Gain and Offset Calibrator

This block is a streaming correction stage for an energy meter. It receives filtered active power samples, one per valid cycle, and returns corrected samples. Each sample first receives a signed offset correction. The offset is held in a register whose least significant bit is worth 1/256 of one sample LSB. The sum is then scaled by a signed fractional gain centred on unity. The result is rounded to the nearest integer and clamped to the signed sample range.

Two calibration words are loaded through a simple write port. The gain word is 12-bit two's complement and scales the output by (1 + gain/4096), which covers 50% to roughly 150% of nominal. The offset word is 16-bit two's complement and is used to force the output to zero under no load. Each accepted sample takes a snapshot of both words. A write therefore never alters a sample that is already in flight.

Top module: `apw_calibrator`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid` is 0 and `out_data` is 0. After reset the gain and offset words are both 0, which means unity gain and no offset.
- R2: A sample accepted on a rising edge (`in_valid` high) produces `out_valid` high after the second rising edge counted from that one, and never after the first. Samples may arrive on consecutive cycles, and each one produces exactly one output cycle.
- R3: The offset word is added as a 16-bit two's complement value with 8 fractional bits: corrected = in_data + offset/256. For example, in_data 1 with offset 0xFF00 gives exactly 0.
- R4: The gain word is 12-bit two's complement and multiplies the offset-corrected value by (4096 + gain)/4096. Gain 0x7FF applies 6143/4096, gain 0x800 applies 2048/4096, and gain 0x400 applies 1.25.
- R5: The scaled value is rounded to the nearest integer, with exact halves going toward positive infinity: +0.5 gives 1 and −0.5 gives 0.
- R6: The output saturates to the signed 24-bit range [−0x800000, 0x7FFFFF] and never wraps. A non-negative corrected value never produces a negative output.
- R7: With `wr_en` high on a rising edge, `wr_sel` 0 loads the gain from `wr_data[11:0]` and `wr_sel` 1 loads the offset from `wr_data[15:0]`. A sample accepted on the same edge as a write, or on an earlier edge, uses the previous value. Samples accepted on later edges use the new value.
- R8: While `out_valid` is 0, `out_data` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Calibration register write strobe |
| wr_sel | input | 1 | 0 selects the gain word, 1 selects the offset word |
| wr_data | input | 16 | Write data (the gain uses bits 11:0) |
| in_valid | input | 1 | Input sample valid |
| in_data | input | 24 | Filtered active power sample, two's complement |
| out_valid | output | 1 | Corrected sample valid |
| out_data | output | 24 | Corrected active power, two's complement |

## Verification
The bench builds the block with its default parameters: 24-bit samples, a 12-bit gain, a 16-bit offset, 8 offset fraction bits and round-to-nearest. With these values both gain extremes can be applied to the nominal full-scale value 0xCCCCD, and the rails of the 24-bit range can be driven into saturation. The 1/256 offset resolution is also fine enough that the exact rounding ties at ±0.5 LSB can be hit with a single offset word. Further cases cover writes that coincide with an accepted sample or land mid-pipeline, back-to-back samples, and output hold while idle.

// File: rtl/apw_cal_pkg.sv
package apw_cal_pkg;

  // Write-port register select
  typedef enum logic {
    CAL_SEL_GAIN   = 1'b0,
    CAL_SEL_OFFSET = 1'b1
  } cal_sel_e;

  // Default widths shared by the design and its checker
  localparam int unsigned CAL_DATA_W = 24;
  localparam int unsigned CAL_GAIN_W = 12;
  localparam int unsigned CAL_OFS_W  = 16;
  localparam int unsigned CAL_FRAC_W = 8;

endpackage

// File: rtl/apw_cal_regs.sv
module apw_cal_regs #(
  parameter int unsigned GAIN_W = 12,
  parameter int unsigned OFS_W  = 16,
  parameter int unsigned WR_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     wr_sel,
  input  logic [WR_W-1:0]          wr_data,
  output logic signed [GAIN_W-1:0] gain_q,
  output logic signed [OFS_W-1:0]  ofs_q
);
  import apw_cal_pkg::*;

  cal_sel_e sel;
  assign sel = cal_sel_e'(wr_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_q <= '0;
      ofs_q  <= '0;
    end else if (wr_en) begin
      if (sel == CAL_SEL_GAIN) gain_q <= wr_data[GAIN_W-1:0];
      else                     ofs_q  <= wr_data[OFS_W-1:0];
    end
  end

endmodule

// File: rtl/apw_cal_offset_stage.sv
module apw_cal_offset_stage #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned GAIN_W = 12,
  parameter int unsigned OFS_W  = 16,
  parameter int unsigned FRAC_W = 8,
  localparam int unsigned SUM_W = DATA_W + FRAC_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  input  logic signed [GAIN_W-1:0] gain_i,
  input  logic signed [OFS_W-1:0]  ofs_i,
  output logic                     s1_valid,
  output logic signed [SUM_W-1:0]  s1_sum,
  output logic signed [GAIN_W-1:0] s1_gain
);

  logic signed [SUM_W-1:0] data_ext;
  logic signed [SUM_W-1:0] ofs_ext;
  logic signed [SUM_W-1:0] sum_d;

  // Sample moved up by FRAC_W bits so the offset lands on its fractional grid
  assign data_ext = {in_data[DATA_W-1], in_data, {FRAC_W{1'b0}}};
  assign ofs_ext  = {{(SUM_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i};
  assign sum_d    = data_ext + ofs_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_sum   <= '0;
      s1_gain  <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_sum  <= sum_d;
        s1_gain <= gain_i;
      end
    end
  end

endmodule

// File: rtl/apw_cal_gain_stage.sv
module apw_cal_gain_stage #(
  parameter int unsigned DATA_W        = 24,
  parameter int unsigned GAIN_W        = 12,
  parameter int unsigned FRAC_W        = 8,
  parameter bit          ROUND_NEAREST = 1'b1,
  localparam int unsigned SUM_W  = DATA_W + FRAC_W + 1,
  localparam int unsigned MULT_W = GAIN_W + 2,
  localparam int unsigned PROD_W = SUM_W + MULT_W,
  localparam int unsigned SHIFT  = FRAC_W + GAIN_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     s1_valid,
  input  logic signed [SUM_W-1:0]  s1_sum,
  input  logic signed [GAIN_W-1:0] s1_gain,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_data
);

  localparam logic signed [MULT_W-1:0] UNITY = {2'b01, {GAIN_W{1'b0}}};
  localparam logic signed [PROD_W-1:0] MAXV  =
    {{(PROD_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [PROD_W-1:0] MINV  =
    {{(PROD_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  logic signed [MULT_W-1:0] factor;
  logic signed [PROD_W-1:0] sum_ext;
  logic signed [PROD_W-1:0] factor_ext;
  logic signed [PROD_W-1:0] product;
  logic signed [PROD_W-1:0] bias;
  logic signed [PROD_W-1:0] biased;
  logic signed [PROD_W-1:0] scaled;
  logic signed [DATA_W-1:0] clamped;

  assign factor     = UNITY + {{2{s1_gain[GAIN_W-1]}}, s1_gain};
  assign sum_ext    = {{MULT_W{s1_sum[SUM_W-1]}}, s1_sum};
  assign factor_ext = {{SUM_W{factor[MULT_W-1]}}, factor};
  assign product    = sum_ext * factor_ext;

  generate
    if (ROUND_NEAREST) begin : g_round
      assign bias = {{(PROD_W-SHIFT){1'b0}}, 1'b1, {(SHIFT-1){1'b0}}};
    end else begin : g_trunc
      assign bias = '0;
    end
  endgenerate

  assign biased = product + bias;
  assign scaled = biased >>> SHIFT;

  always_comb begin
    if (scaled > MAXV)      clamped = MAXV[DATA_W-1:0];
    else if (scaled < MINV) clamped = MINV[DATA_W-1:0];
    else                    clamped = scaled[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_data <= clamped;
    end
  end

endmodule

// File: rtl/apw_calibrator.sv
module apw_calibrator #(
  parameter int unsigned DATA_W        = apw_cal_pkg::CAL_DATA_W,
  parameter int unsigned GAIN_W        = apw_cal_pkg::CAL_GAIN_W,
  parameter int unsigned OFS_W         = apw_cal_pkg::CAL_OFS_W,
  parameter int unsigned FRAC_W        = apw_cal_pkg::CAL_FRAC_W,
  parameter bit          ROUND_NEAREST = 1'b1,
  localparam int unsigned SUM_W = DATA_W + FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [OFS_W-1:0]  wr_data,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  logic signed [GAIN_W-1:0] gain_q;
  logic signed [OFS_W-1:0]  ofs_q;
  logic                     s1_valid;
  logic signed [SUM_W-1:0]  s1_sum;
  logic signed [GAIN_W-1:0] s1_gain;
  logic signed [DATA_W-1:0] out_s;

  apw_cal_regs #(
    .GAIN_W (GAIN_W),
    .OFS_W  (OFS_W),
    .WR_W   (OFS_W)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .gain_q  (gain_q),
    .ofs_q   (ofs_q)
  );

  apw_cal_offset_stage #(
    .DATA_W (DATA_W),
    .GAIN_W (GAIN_W),
    .OFS_W  (OFS_W),
    .FRAC_W (FRAC_W)
  ) u_ofs (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .gain_i   (gain_q),
    .ofs_i    (ofs_q),
    .s1_valid (s1_valid),
    .s1_sum   (s1_sum),
    .s1_gain  (s1_gain)
  );

  apw_cal_gain_stage #(
    .DATA_W        (DATA_W),
    .GAIN_W        (GAIN_W),
    .FRAC_W        (FRAC_W),
    .ROUND_NEAREST (ROUND_NEAREST)
  ) u_gain (
    .clk       (clk),
    .rst       (rst),
    .s1_valid  (s1_valid),
    .s1_sum    (s1_sum),
    .s1_gain   (s1_gain),
    .out_valid (out_valid),
    .out_data  (out_s)
  );

  assign out_data = out_s;

endmodule

// File: rtl/apw_calibrator_chk.sv
module apw_calibrator_chk #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned GAIN_W = 12,
  parameter int unsigned OFS_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [OFS_W-1:0]  wr_data,
  input logic              in_valid,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic [GAIN_W-1:0] gain_q,
  input logic [OFS_W-1:0]  ofs_q,
  input logic              s1_valid,
  input logic              s1_sum_neg
);

  AST_RESET_REGS: assert property (@(posedge clk)
    $fell(rst) |-> (gain_q == '0) && (ofs_q == '0) && !out_valid); // R1

  AST_LAT_FWD: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid); // R2

  AST_LAT_BWD: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2)); // R2

  AST_GAIN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sel) |=> gain_q == $past(wr_data[GAIN_W-1:0])); // R7

  AST_OFS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel) |=> ofs_q == $past(wr_data)); // R7

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !s1_sum_neg) |=> !out_data[DATA_W-1]); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> $stable(out_data)); // R8

endmodule

bind apw_calibrator apw_calibrator_chk #(
  .DATA_W (DATA_W),
  .GAIN_W (GAIN_W),
  .OFS_W  (OFS_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .gain_q     (gain_q),
  .ofs_q      (ofs_q),
  .s1_valid   (s1_valid),
  .s1_sum_neg (s1_sum[SUM_W-1])
);

// File: tb/apw_calibrator_tb.sv
module apw_calibrator_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        in_valid = 1'b0;
  logic [23:0] in_data = '0;
  logic        out_valid;
  logic [23:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  apw_calibrator u_dut (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  typedef struct packed {
    logic [23:0] din;
    logic [11:0] gain;
    logic [15:0] ofs;
    logic [23:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{din: 24'd1000,    gain: 12'h000, ofs: 16'h0000, exp: 24'd1000},    // R4 unity
    '{din: 24'h0CCCCD,  gain: 12'h7FF, ofs: 16'h0000, exp: 24'h133267},  // R4 max gain
    '{din: 24'h0CCCCD,  gain: 12'h800, ofs: 16'h0000, exp: 24'h066667},  // R4 min gain, R5 tie
    '{din: 24'd1,       gain: 12'h000, ofs: 16'hFF00, exp: 24'h000000},  // R3 cancel
    '{din: 24'd0,       gain: 12'h000, ofs: 16'h0080, exp: 24'h000001},  // R5 +0.5
    '{din: 24'd0,       gain: 12'h000, ofs: 16'hFF80, exp: 24'h000000},  // R5 -0.5
    '{din: 24'd0,       gain: 12'h000, ofs: 16'hFF7F, exp: 24'hFFFFFF},  // R5 below -0.5
    '{din: 24'h7FFFFF,  gain: 12'h7FF, ofs: 16'h0000, exp: 24'h7FFFFF},  // R6 top rail
    '{din: 24'h800000,  gain: 12'h7FF, ofs: 16'h0000, exp: 24'h800000},  // R6 bottom rail
    '{din: 24'hFFFC18,  gain: 12'h400, ofs: 16'h0000, exp: 24'hFFFB1E},  // R4 -1000*1.25
    '{din: 24'd100,     gain: 12'h000, ofs: 16'h0100, exp: 24'd101},     // R3 one LSB
    '{din: 24'hF33333,  gain: 12'h7FF, ofs: 16'h0000, exp: 24'hECCD99}   // R4 negative
  };

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%06h expected 0x%06h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic sel, input logic [15:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Accept one sample, confirm no output one edge later, return output two edges later
  task automatic run_sample(input logic [23:0] din, input string req, output logic [23:0] res);
    @(negedge clk);
    in_valid = 1'b1; in_data = din;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R2 early"}, {23'd0, out_valid}, 24'd0);
    @(negedge clk);
    check({req, " R2 valid"}, {23'd0, out_valid}, 24'd1);
    res = out_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [23:0] r;
    repeat (3) @(negedge clk);
    // R1: outputs cleared during reset
    check("R1 valid in reset", {23'd0, out_valid}, 24'd0);
    check("R1 data in reset", out_data, 24'd0);
    @(negedge clk);
    rst = 1'b0;
    check("R1 valid after reset", {23'd0, out_valid}, 24'd0);
    // R1: unity gain, zero offset after reset
    run_sample(24'd12345, "R1 unity", r);
    check("R1 default scaling", r, 24'd12345);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      write_reg(1'b0, {4'd0, VECS[i].gain});
      write_reg(1'b1, VECS[i].ofs);
      run_sample(VECS[i].din, $sformatf("R3-6 vec%0d", i), r);
      check($sformatf("R4 vec%0d", i), r, VECS[i].exp);
    end

    // R8: output holds while idle
    repeat (4) begin
      @(negedge clk);
      check("R8 idle valid", {23'd0, out_valid}, 24'd0);
      check("R8 idle hold", out_data, VECS[NV-1].exp);
    end

    // R7: write during flight does not touch accepted sample
    write_reg(1'b0, 16'h0000);
    write_reg(1'b1, 16'h0000);
    @(negedge clk);
    in_valid = 1'b1; in_data = 24'd1000;
    @(negedge clk);
    in_valid = 1'b0;
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'h0400;
    @(negedge clk);
    wr_en = 1'b0;
    check("R7 in-flight", out_data, 24'd1000);
    // R7: write on same edge as acceptance uses old gain (1.25)
    @(negedge clk);
    in_valid = 1'b1; in_data = 24'd1000;
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'h0800;
    @(negedge clk);
    in_valid = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    check("R7 same-edge old", out_data, 24'd1250);
    run_sample(24'd1000, "R7 next", r);
    check("R7 new value", r, 24'd500);

    // R2: back-to-back samples, gain 0.5
    @(negedge clk);
    in_valid = 1'b1; in_data = 24'd10;
    @(negedge clk);
    in_data = 24'd20;
    @(negedge clk);
    in_data = 24'd30;
    check("R2 b2b first", out_data, 24'd5);
    check("R2 b2b v1", {23'd0, out_valid}, 24'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 b2b second", out_data, 24'd10);
    @(negedge clk);
    check("R2 b2b third", out_data, 24'd15);
    check("R2 b2b v3", {23'd0, out_valid}, 24'd1);
    @(negedge clk);
    check("R2 b2b end", {23'd0, out_valid}, 24'd0);

    // R1: reset mid-run restores defaults
    write_reg(1'b1, 16'h1000);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset data", out_data, 24'd0);
    rst = 1'b0;
    run_sample(24'd777, "R1 re-reset", r);
    check("R1 defaults restored", r, 24'd777);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule